// File: doc/BRIEF.md
# Immediate Bit-Manipulation Unit

This block carries out the bit-level immediate operations of an 8-bit accumulator machine. The instruction fetch logic recognises the extended-immediate prefix and hands over the second instruction byte with a valid strobe. The unit also receives the current accumulator value. The second byte must have the form `10oooiii`. The three `ooo` bits select one of eight operations. The three `iii` bits are used either as a shift or rotate count or as a bit index, depending on the operation.

The result always replaces the accumulator. It is held in a register inside the unit and appears on the output after the clock edge on which the strobe was high. When the strobe is low, or when the byte does not belong to this class, the register keeps its value. The shift path can be built as a logarithmic barrel shifter or as a flat multiplexer over every possible amount. A parameter chooses between the two, and both give the same results.

Top module: `bitimm_unit`

## Requirements
- R1: While reset is asserted, and after it is released, the accumulator output is 0 until the first accepted operation.
- R2: On a clock edge where `valid_i` is low, `acc_o` keeps its value.
- R3: On a clock edge where `valid_i` is high but `imm_i[7:6]` is not binary `10`, `acc_o` keeps its value.
- R4: `ooo = 000` rotates the accumulator left by `iii` positions. Bit j moves to bit (j+iii) mod 8.
- R5: `ooo = 001` shifts left by `iii` and fills with zeros.
- R6: `ooo = 010` shifts right by `iii` and fills with zeros.
- R7: `ooo = 011` shifts right by `iii` and fills the vacated bits with copies of bit 7.
- R8: `ooo = 100` forces bit `iii` to 0 and leaves the other bits unchanged.
- R9: `ooo = 101` forces bit `iii` to 1 and leaves the other bits unchanged.
- R10: `ooo = 110` inverts bit `iii` and leaves the other bits unchanged.
- R11: `ooo = 111` sets the accumulator to 1 when bit `iii` of the input is 1, and to 0 otherwise.
- R12: A rotate or shift with `iii = 0` returns the input accumulator unchanged.
- R13: A result is registered. `acc_o` changes only on the rising edge where an operation is accepted, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Strobe: apply `imm_i` to `acc_i` on this edge |
| acc_i | input | 8 | Current accumulator value |
| imm_i | input | 8 | Second instruction byte, `10oooiii` |
| acc_o | output | 8 | Registered accumulator result |

## Verification
Random accumulator values are paired with random operation bytes. The draw covers all eight opcodes and all eight index values, so each opcode is seen both as a shift amount and as a bit index. Directed cases then target the points where similar operations must differ. Arithmetic and logical right shifts are fed inputs with bit 7 set. Rotate and left shift are fed values whose top bits are set, which separates wrap-around from zero fill. Extract is applied to set bits and to clear bits, and every shift is also tried with amount zero. Bytes with the wrong class bits and cycles with the strobe low are mixed into the stream to show that the register holds.

// File: rtl/bitimm_pkg.sv
package bitimm_pkg;
   // width of the operand field inside the instruction byte
   localparam int IDX_W = 3;
   localparam int OP_W  = 3;

   typedef enum logic [OP_W-1:0] {
      OP_ROL = 3'd0,
      OP_LSL = 3'd1,
      OP_LSR = 3'd2,
      OP_ASR = 3'd3,
      OP_CLR = 3'd4,
      OP_SET = 3'd5,
      OP_TOG = 3'd6,
      OP_EXT = 3'd7
   } bitop_e;

   // class tag carried in the two top bits of the instruction byte
   localparam logic [1:0] CLASS_TAG = 2'b10;
endpackage

// File: rtl/bitimm_decode.sv
module bitimm_decode
   import bitimm_pkg::*;
(
   input  logic [7:0]       imm_i,
   output logic             hit_o,
   output bitop_e           op_o,
   output logic [IDX_W-1:0] arg_o
);
   always_comb begin
      hit_o = (imm_i[7:6] == CLASS_TAG);
      op_o  = bitop_e'(imm_i[5:3]);
      arg_o = imm_i[2:0];
   end
endmodule

// File: rtl/bitimm_shift_step.sv
module bitimm_shift_step #(
   parameter int W = 8,
   parameter int S = 1
) (
   input  logic [W-1:0] d_i,
   input  logic [1:0]   sel_i,
   output logic [W-1:0] q_o
);
   generate
      if (S == 0) begin : g_pass
         logic [1:0] unused_sel;
         assign unused_sel = sel_i;
         assign q_o = d_i;
      end else begin : g_move
         always_comb begin
            case (sel_i)
               2'd0:    q_o = {d_i[W-1-S:0], d_i[W-1:W-S]};
               2'd1:    q_o = {d_i[W-1-S:0], {S{1'b0}}};
               2'd2:    q_o = {{S{1'b0}}, d_i[W-1:S]};
               default: q_o = {{S{d_i[W-1]}}, d_i[W-1:S]};
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/bitimm_shifter.sv
module bitimm_shifter #(
   parameter int W           = 8,
   parameter bit LOG_SHIFTER = 1'b1,
   localparam int AW         = $clog2(W)
) (
   input  logic [W-1:0]  d_i,
   input  logic [1:0]    sel_i,
   input  logic [AW-1:0] amt_i,
   output logic [W-1:0]  q_o
);
   generate
      if (W != (1 << AW)) begin : g_bad_w
         $error("bitimm_shifter: W must be a power of two");
      end

      if (LOG_SHIFTER) begin : g_log
         logic [AW:0][W-1:0] stage;
         assign stage[0] = d_i;
         for (genvar k = 0; k < AW; k++) begin : g_stage
            logic [W-1:0] moved;
            bitimm_shift_step #(.W(W), .S(1 << k)) step_i (
               .d_i   (stage[k]),
               .sel_i (sel_i),
               .q_o   (moved)
            );
            assign stage[k+1] = amt_i[k] ? moved : stage[k];
         end
         assign q_o = stage[AW];
      end else begin : g_flat
         logic [W-1:0][W-1:0] cand;
         for (genvar n = 0; n < W; n++) begin : g_amt
            bitimm_shift_step #(.W(W), .S(n)) step_i (
               .d_i   (d_i),
               .sel_i (sel_i),
               .q_o   (cand[n])
            );
         end
         assign q_o = cand[amt_i];
      end
   endgenerate
endmodule

// File: rtl/bitimm_bitop.sv
module bitimm_bitop #(
   parameter int W   = 8,
   localparam int AW = $clog2(W)
) (
   input  logic [W-1:0]  d_i,
   input  logic [1:0]    sel_i,
   input  logic [AW-1:0] idx_i,
   output logic [W-1:0]  q_o
);
   logic [W-1:0] mask;

   always_comb begin
      mask = '0;
      mask[idx_i] = 1'b1;
      case (sel_i)
         2'd0:    q_o = d_i & ~mask;
         2'd1:    q_o = d_i | mask;
         2'd2:    q_o = d_i ^ mask;
         default: q_o = {{(W-1){1'b0}}, d_i[idx_i]};
      endcase
   end
endmodule

// File: rtl/bitimm_unit.sv
module bitimm_unit
   import bitimm_pkg::*;
#(
   parameter int         DATA_W      = 8,
   parameter bit         LOG_SHIFTER = 1'b1,
   parameter logic [7:0] RESET_VAL   = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_i,
   input  logic [DATA_W-1:0] acc_i,
   input  logic [7:0]        imm_i,
   output logic [DATA_W-1:0] acc_o
);
   generate
      if (DATA_W != (1 << IDX_W)) begin : g_bad_width
         $error("bitimm_unit: DATA_W must match the 3-bit index field");
      end
   endgenerate

   logic             hit;
   bitop_e           op;
   logic [IDX_W-1:0] arg;
   logic [DATA_W-1:0] shift_res, bit_res, next_acc, acc_q;

   bitimm_decode dec_i (
      .imm_i (imm_i),
      .hit_o (hit),
      .op_o  (op),
      .arg_o (arg)
   );

   bitimm_shifter #(.W(DATA_W), .LOG_SHIFTER(LOG_SHIFTER)) shf_i (
      .d_i   (acc_i),
      .sel_i (op[1:0]),
      .amt_i (arg),
      .q_o   (shift_res)
   );

   bitimm_bitop #(.W(DATA_W)) bop_i (
      .d_i   (acc_i),
      .sel_i (op[1:0]),
      .idx_i (arg),
      .q_o   (bit_res)
   );

   assign next_acc = op[2] ? bit_res : shift_res;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc_q <= RESET_VAL[DATA_W-1:0];
      else if (valid_i && hit)
         acc_q <= next_acc;
   end

   assign acc_o = acc_q;

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> (acc_o == $past(acc_o)));

   // R3
   foreign_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && imm_i[7:6] != 2'b10) |=> (acc_o == $past(acc_o)));

   // R7
   asr_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && imm_i[7:3] == 5'b10011) |=> (acc_o[DATA_W-1] == $past(acc_i[DATA_W-1])));

   // R8
   clear_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && imm_i[7:3] == 5'b10100) |=> !acc_o[$past(imm_i[2:0])]);

   // R9
   insert_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && imm_i[7:3] == 5'b10101) |=> acc_o[$past(imm_i[2:0])]);

   // R11
   extract_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && imm_i[7:3] == 5'b10111) |=> (acc_o[DATA_W-1:1] == '0));

   // R12
   zero_amount_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && imm_i[7:5] == 3'b100 && imm_i[2:0] == 3'd0) |=> (acc_o == $past(acc_i)));
endmodule

// File: tb/bitimm_unit_tb.sv
module bitimm_unit_tb_top;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       valid_i = 1'b0;
   logic [7:0] acc_i = 8'h00;
   logic [7:0] imm_i = 8'h00;
   logic [7:0] acc_o;

   int n_checks = 0;
   int n_fails  = 0;
   logic [7:0] expect_q = 8'h00;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bitimm_unit dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid_i (valid_i),
      .acc_i   (acc_i),
      .imm_i   (imm_i),
      .acc_o   (acc_o)
   );

   function automatic logic [7:0] model(input logic [7:0] a, input logic [7:0] imm);
      logic [7:0] r;
      int n;
      n = int'(imm[2:0]);
      r = a;
      case (imm[5:3])
         3'd0: for (int j = 0; j < 8; j++) r[(j + n) % 8] = a[j];
         3'd1: r = a << n;
         3'd2: r = a >> n;
         3'd3: for (int j = 0; j < 8; j++) r[j] = (j + n > 7) ? a[7] : a[j + n];
         3'd4: r[n] = 1'b0;
         3'd5: r[n] = 1'b1;
         3'd6: r[n] = ~a[n];
         default: r = {7'b0, a[n]};
      endcase
      return r;
   endfunction

   function automatic string req_of(input logic v, input logic [7:0] imm);
      if (!v) return "R2";
      if (imm[7:6] != 2'b10) return "R3";
      if (!imm[5] && imm[2:0] == 3'd0) return "R12";
      case (imm[5:3])
         3'd0: return "R4";
         3'd1: return "R5";
         3'd2: return "R6";
         3'd3: return "R7";
         3'd4: return "R8";
         3'd5: return "R9";
         3'd6: return "R10";
         default: return "R11";
      endcase
   endfunction

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fails++;
         $display("FAIL %s: acc_o=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic step(input logic v, input logic [7:0] a, input logic [7:0] imm);
      @(negedge clk);
      valid_i = v;
      acc_i   = a;
      imm_i   = imm;
      #1;
      // R13: nothing moves before the edge
      check("R13", acc_o, expect_q);
      if (v && imm[7:6] == 2'b10) expect_q = model(a, imm);
      @(posedge clk);
      #1;
      check(req_of(v, imm), acc_o, expect_q);
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      #1;
      check("R1", acc_o, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check("R1", acc_o, 8'h00);

      // directed corners
      step(1'b1, 8'hC1, 8'b10_000_011);   // R4 rotate wrap
      step(1'b1, 8'hC1, 8'b10_001_011);   // R5 zero fill
      step(1'b1, 8'h96, 8'b10_010_111);   // R6
      step(1'b1, 8'h96, 8'b10_011_111);   // R7 sign fill
      step(1'b1, 8'h96, 8'b10_011_000);   // R12
      step(1'b1, 8'h5A, 8'b10_000_000);   // R12
      step(1'b1, 8'hFF, 8'b10_100_111);   // R8
      step(1'b1, 8'h00, 8'b10_101_000);   // R9
      step(1'b1, 8'h0F, 8'b10_110_100);   // R10
      step(1'b1, 8'h80, 8'b10_111_111);   // R11 set bit
      step(1'b1, 8'h7F, 8'b10_111_111);   // R11 clear bit
      step(1'b0, 8'h33, 8'b10_101_110);   // R2
      step(1'b1, 8'h33, 8'b01_101_110);   // R3
      step(1'b1, 8'h33, 8'b11_000_001);   // R3

      for (int i = 0; i < 3000; i++) begin
         logic [7:0] a, imm;
         logic v;
         a   = 8'($urandom);
         imm = 8'($urandom);
         if (($urandom % 8) != 0) imm[7:6] = 2'b10;
         v = (($urandom % 6) != 0);
         step(v, a, imm);
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: acc_o=%h expected=end of run", acc_o);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end
endmodule